// File: doc/BRIEF.md
# Memory-Mapped Modulo Timer with Interrupt

This block is an AXI4-Lite slave that holds a free-running modulo counter and four 32-bit registers. Software writes a terminal value, called the modulo, and sets an enable bit. While the timer is enabled, the counter steps from zero up to modulo minus one and then returns to zero. A period therefore lasts exactly `modulo` clocks. For example, a modulo of 0x5F5E100 gives a period of 100,000,000 clocks.

A terminal-count flag is high whenever the count is at or beyond its last value. Software reads the flag back together with the enable bit. The live count is readable at a separate address. A single interrupt request output carries a registered copy of the flag. It is meant for an interrupt controller that detects rising edges, so each period produces one rising edge.

Reset is synchronous and active high. It clears every register, the count and the interrupt output. After reset the modulo is zero, which behaves like a modulo of one, so the flag is high at once.

Top module: `axil_mod_timer`

## Requirements
- R1: While `rst` is high and in the first cycle after it falls, all registers read zero, the counter is zero, `irq` is 0 and neither `s_bvalid` nor `s_rvalid` is set.
- R2: The word at byte offset 0x0 holds the modulo and is readable and writable. Each `s_wstrb` bit enables one byte lane, so `s_wstrb[k]` writes bits 8k+7..8k.
- R3: The word at offset 0x4 stores bits 31..1 as written, with byte strobes. Bit 1 is the count enable. Bit 0 is not stored; on a read it returns the terminal-count flag.
- R4: The word at offset 0x8 reads the current count. A write to it completes with an OKAY response and leaves the count, the flag and every register unchanged.
- R5: The word at offset 0xC is a scratch register, readable and writable with byte strobes.
- R6: While the enable is 1 and the flag is low, the count rises by one on each clock. While the enable is 0, the count holds its value.
- R7: While enabled, the count returns to 0 on the clock after it reaches modulo−1. Successive rising edges of `irq` are therefore `modulo` clocks apart.
- R8: The flag is high whenever count ≥ modulo−1, including after the modulo is lowered below the current count. In that case the next enabled clock returns the count to 0.
- R9: A modulo of 0 acts like a modulo of 1. The flag stays high and an enabled count stays at 0.
- R10: `irq` equals the flag as it was one clock earlier.
- R11: `s_bresp` and `s_rresp` are always 0 (OKAY). The write response stays valid until `s_bready` is high. Read data and `s_rvalid` stay unchanged until `s_rready` is high. Each write or read address is accepted once per transfer.
- R12: A read returns the register contents from before the edge on which its address is accepted. The count read is the value held in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| s_awaddr | input | ADDR_W | Write byte address |
| s_awvalid | input | 1 | Write address valid |
| s_awready | output | 1 | Write address ready |
| s_wdata | input | DATA_W | Write data |
| s_wstrb | input | DATA_W/8 | Write byte enables |
| s_wvalid | input | 1 | Write data valid |
| s_wready | output | 1 | Write data ready |
| s_bresp | output | 2 | Write response, always OKAY |
| s_bvalid | output | 1 | Write response valid |
| s_bready | input | 1 | Write response ready |
| s_araddr | input | ADDR_W | Read byte address |
| s_arvalid | input | 1 | Read address valid |
| s_arready | output | 1 | Read address ready |
| s_rdata | output | DATA_W | Read data |
| s_rresp | output | 2 | Read response, always OKAY |
| s_rvalid | output | 1 | Read data valid |
| s_rready | input | 1 | Read data ready |
| irq | output | 1 | Interrupt request, registered terminal-count flag |

## Verification
The assertions assume a manager that keeps each valid signal high, with stable address and data, until the matching ready is seen. They also assume the manager presents the write address and the write data together. The bench drives every transfer through tasks that follow this rule and deasserts valid just after the accepting edge. It holds the response ready signals low for a random number of cycles so that the holding properties are exercised.

Random modulo values are kept small, so wrap-around happens many times within the run. The modulo value zero and lowering the modulo below the current count are driven as directed cases.

// File: rtl/mtmr_pkg.sv
package mtmr_pkg;
  localparam int unsigned REG_NUM = 4;
  localparam int unsigned IDX_W   = $clog2(REG_NUM);

  typedef enum logic [IDX_W-1:0] {
    IDX_MOD   = 2'd0,
    IDX_CTRL  = 2'd1,
    IDX_COUNT = 2'd2,
    IDX_SCR   = 2'd3
  } reg_idx_e;

  localparam logic [1:0] RESP_OKAY = 2'b00;
  localparam int unsigned EN_BIT   = 1;
endpackage

// File: rtl/mtmr_axil_port.sv
module mtmr_axil_port #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [ADDR_W-1:0]           awaddr,
  input  logic                        awvalid,
  output logic                        awready,
  input  logic [DATA_W-1:0]           wdata,
  input  logic [STRB_W-1:0]           wstrb,
  input  logic                        wvalid,
  output logic                        wready,
  output logic                        bvalid,
  input  logic                        bready,
  input  logic [ADDR_W-1:0]           araddr,
  input  logic                        arvalid,
  output logic                        arready,
  output logic [DATA_W-1:0]           rdata,
  output logic                        rvalid,
  input  logic                        rready,
  output logic                        wr_en,
  output mtmr_pkg::reg_idx_e          wr_idx,
  output logic [DATA_W-1:0]           wr_data,
  output logic [STRB_W-1:0]           wr_strb,
  output mtmr_pkg::reg_idx_e          rd_idx,
  input  logic [DATA_W-1:0]           rd_word
);
  import mtmr_pkg::*;

  logic aw_q, ar_q;
  logic wr_go, rd_go, rd_take;
  logic unused_lsb;

  assign unused_lsb = ^{awaddr[1:0], araddr[1:0]};

  assign wr_go   = awvalid && wvalid && !aw_q && !bvalid;
  assign rd_go   = arvalid && !ar_q && !rvalid;
  assign wr_en   = aw_q && awvalid && wvalid;
  assign rd_take = ar_q && arvalid;

  assign wr_idx  = reg_idx_e'(awaddr[IDX_W+1:2]);
  assign rd_idx  = reg_idx_e'(araddr[IDX_W+1:2]);
  assign wr_data = wdata;
  assign wr_strb = wstrb;
  assign awready = aw_q;
  assign wready  = aw_q;
  assign arready = ar_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      aw_q   <= 1'b0;
      bvalid <= 1'b0;
    end else begin
      aw_q <= wr_go;
      if (wr_en)
        bvalid <= 1'b1;
      else if (bready)
        bvalid <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ar_q   <= 1'b0;
      rvalid <= 1'b0;
      rdata  <= '0;
    end else begin
      ar_q <= rd_go;
      if (rd_take) begin
        rvalid <= 1'b1;
        rdata  <= rd_word;
      end else if (rready) begin
        rvalid <= 1'b0;
      end
    end
  end
endmodule

// File: rtl/mtmr_regs.sv
module mtmr_regs #(
  parameter int unsigned DATA_W = 32,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  wr_en,
  input  mtmr_pkg::reg_idx_e    wr_idx,
  input  logic [DATA_W-1:0]     wr_data,
  input  logic [STRB_W-1:0]     wr_strb,
  input  mtmr_pkg::reg_idx_e    rd_idx,
  output logic [DATA_W-1:0]     rd_word,
  input  logic [DATA_W-1:0]     cnt,
  input  logic                  tc,
  output logic [DATA_W-1:0]     modulo,
  output logic                  en
);
  import mtmr_pkg::*;

  logic [DATA_W-1:0] mod_q, ctrl_q, scr_q;

  for (genvar b = 0; b < STRB_W; b++) begin : g_lane
    always_ff @(posedge clk) begin
      if (rst) begin
        mod_q[8*b +: 8]  <= '0;
        ctrl_q[8*b +: 8] <= '0;
        scr_q[8*b +: 8]  <= '0;
      end else if (wr_en && wr_strb[b]) begin
        case (wr_idx)
          IDX_MOD:  mod_q[8*b +: 8]  <= wr_data[8*b +: 8];
          IDX_CTRL: ctrl_q[8*b +: 8] <= wr_data[8*b +: 8];
          IDX_SCR:  scr_q[8*b +: 8]  <= wr_data[8*b +: 8];
          default:  ;
        endcase
      end
    end
  end

  assign modulo = mod_q;
  assign en     = ctrl_q[EN_BIT];

  always_comb begin
    case (rd_idx)
      IDX_MOD:   rd_word = mod_q;
      IDX_CTRL:  rd_word = {ctrl_q[DATA_W-1:1], tc};
      IDX_COUNT: rd_word = cnt;
      default:   rd_word = scr_q;
    endcase
  end
endmodule

// File: rtl/mtmr_counter.sv
module mtmr_counter #(
  parameter int unsigned CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             en,
  input  logic [CNT_W-1:0] modulo,
  output logic [CNT_W-1:0] cnt,
  output logic             tc,
  output logic             irq
);
  logic [CNT_W-1:0] last;

  assign last = (modulo == '0) ? '0 : modulo - 1'b1;
  assign tc   = (cnt >= last);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
      irq <= 1'b0;
    end else begin
      irq <= tc;
      if (en)
        cnt <= tc ? '0 : cnt + 1'b1;
    end
  end
endmodule

// File: rtl/axil_mod_timer.sv
module axil_mod_timer #(
  parameter int unsigned ADDR_W = 4,
  parameter int unsigned DATA_W = 32,
  localparam int unsigned STRB_W = DATA_W / 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] s_awaddr,
  input  logic              s_awvalid,
  output logic              s_awready,
  input  logic [DATA_W-1:0] s_wdata,
  input  logic [STRB_W-1:0] s_wstrb,
  input  logic              s_wvalid,
  output logic              s_wready,
  output logic [1:0]        s_bresp,
  output logic              s_bvalid,
  input  logic              s_bready,
  input  logic [ADDR_W-1:0] s_araddr,
  input  logic              s_arvalid,
  output logic              s_arready,
  output logic [DATA_W-1:0] s_rdata,
  output logic [1:0]        s_rresp,
  output logic              s_rvalid,
  input  logic              s_rready,
  output logic              irq
);
  import mtmr_pkg::*;

  logic               wr_en;
  reg_idx_e           wr_idx, rd_idx;
  logic [DATA_W-1:0]  wr_data, rd_word, modulo, cnt_val;
  logic [STRB_W-1:0]  wr_strb;
  logic               cnt_en, tc_flag;

  assign s_bresp = RESP_OKAY;
  assign s_rresp = RESP_OKAY;

  mtmr_axil_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) i_port (
    .clk(clk), .rst(rst),
    .awaddr(s_awaddr), .awvalid(s_awvalid), .awready(s_awready),
    .wdata(s_wdata), .wstrb(s_wstrb), .wvalid(s_wvalid), .wready(s_wready),
    .bvalid(s_bvalid), .bready(s_bready),
    .araddr(s_araddr), .arvalid(s_arvalid), .arready(s_arready),
    .rdata(s_rdata), .rvalid(s_rvalid), .rready(s_rready),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_idx(rd_idx), .rd_word(rd_word)
  );

  mtmr_regs #(.DATA_W(DATA_W)) i_regs (
    .clk(clk), .rst(rst),
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_strb(wr_strb),
    .rd_idx(rd_idx), .rd_word(rd_word),
    .cnt(cnt_val), .tc(tc_flag), .modulo(modulo), .en(cnt_en)
  );

  mtmr_counter #(.CNT_W(DATA_W)) i_cnt (
    .clk(clk), .rst(rst), .en(cnt_en), .modulo(modulo),
    .cnt(cnt_val), .tc(tc_flag), .irq(irq)
  );
endmodule

// File: rtl/mtmr_chk.sv
module mtmr_chk #(
  parameter int unsigned DATA_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              bvalid,
  input logic              bready,
  input logic [1:0]        bresp,
  input logic              rvalid,
  input logic              rready,
  input logic [1:0]        rresp,
  input logic [DATA_W-1:0] rdata,
  input logic              irq,
  input logic              tc,
  input logic              en,
  input logic [DATA_W-1:0] cnt
);
  // R11
  bresp_okay_chk: assert property (@(posedge clk) disable iff (rst)
    bvalid |-> bresp == 2'b00);
  // R11
  rresp_okay_chk: assert property (@(posedge clk) disable iff (rst)
    rvalid |-> rresp == 2'b00);
  // R11
  bvalid_hold_chk: assert property (@(posedge clk) disable iff (rst)
    bvalid && !bready |=> bvalid);
  // R11
  rdata_hold_chk: assert property (@(posedge clk) disable iff (rst)
    rvalid && !rready |=> rvalid && $stable(rdata));
  // R10
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> irq == $past(tc));
  // R6
  count_step_chk: assert property (@(posedge clk) disable iff (rst)
    en && !tc |=> cnt == $past(cnt) + 1'b1);
  // R6
  count_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !en |=> $stable(cnt));
  // R7
  count_wrap_chk: assert property (@(posedge clk) disable iff (rst)
    en && tc |=> cnt == '0);
endmodule

bind axil_mod_timer mtmr_chk #(.DATA_W(DATA_W)) i_chk (
  .clk(clk), .rst(rst),
  .bvalid(s_bvalid), .bready(s_bready), .bresp(s_bresp),
  .rvalid(s_rvalid), .rready(s_rready), .rresp(s_rresp), .rdata(s_rdata),
  .irq(irq), .tc(tc_flag), .en(cnt_en), .cnt(cnt_val)
);

// File: tb/test_axil_mod_timer.sv
module test_axil_mod_timer;
  localparam int unsigned CLK_PERIOD = 10;
  localparam int unsigned AW = 4;
  localparam int unsigned DW = 32;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic [AW-1:0] awaddr = '0, araddr = '0;
  logic awvalid = 1'b0, wvalid = 1'b0, bready = 1'b0, arvalid = 1'b0, rready = 1'b0;
  logic [DW-1:0] wdata = '0;
  logic [3:0] wstrb = '0;
  logic awready, wready, bvalid, arready, rvalid, irq;
  logic [1:0] bresp, rresp;
  logic [DW-1:0] rdata;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  // reference state
  logic [DW-1:0] m_mod = '0, m_ctrl = '0, m_scr = '0, m_cnt = '0;
  logic m_irq = 1'b0;
  bit irq_mon = 0;
  int cyc = 0;
  int last_rise = -1;
  int last_period = 0;
  logic irq_prev = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  axil_mod_timer #(.ADDR_W(AW), .DATA_W(DW)) i_axil_mod_timer (
    .clk(clk), .rst(rst),
    .s_awaddr(awaddr), .s_awvalid(awvalid), .s_awready(awready),
    .s_wdata(wdata), .s_wstrb(wstrb), .s_wvalid(wvalid), .s_wready(wready),
    .s_bresp(bresp), .s_bvalid(bvalid), .s_bready(bready),
    .s_araddr(araddr), .s_arvalid(arvalid), .s_arready(arready),
    .s_rdata(rdata), .s_rresp(rresp), .s_rvalid(rvalid), .s_rready(rready),
    .irq(irq)
  );

  function automatic logic m_tc(logic [DW-1:0] c, logic [DW-1:0] m);
    logic [DW-1:0] lim;
    lim = (m == 0) ? '0 : m - 1;
    return c >= lim;
  endfunction

  function automatic logic [DW-1:0] merge(logic [DW-1:0] o, logic [DW-1:0] d, logic [3:0] s);
    logic [DW-1:0] r;
    r = o;
    for (int b = 0; b < 4; b++) if (s[b]) r[8*b +: 8] = d[8*b +: 8];
    return r;
  endfunction

  function automatic logic [DW-1:0] m_read(int idx);
    case (idx)
      0: return m_mod;
      1: return {m_ctrl[DW-1:1], m_tc(m_cnt, m_mod)};
      2: return m_cnt;
      default: return m_scr;
    endcase
  endfunction

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (rst) begin
      m_cnt <= '0;
      m_irq <= 1'b0;
    end else begin
      m_irq <= m_tc(m_cnt, m_mod);
      if (m_ctrl[1]) m_cnt <= m_tc(m_cnt, m_mod) ? '0 : m_cnt + 1;
    end
  end

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // R10 continuous irq check against the model, plus period measurement (R7)
  always @(negedge clk) begin
    if (irq_mon && !rst) check("R10 irq", irq, m_irq);
    if (!rst && irq && !irq_prev) begin
      if (last_rise >= 0) last_period = cyc - last_rise;
      last_rise = cyc;
    end
    irq_prev = irq;
  end

  task automatic wr(int idx, logic [DW-1:0] d, logic [3:0] s, string req);
    int hold;
    @(negedge clk);
    awaddr = AW'(idx * 4); wdata = d; wstrb = s;
    awvalid = 1'b1; wvalid = 1'b1; bready = 1'b0;
    do @(negedge clk); while (!awready);
    @(posedge clk);
    #1;
    case (idx)
      0: m_mod  = merge(m_mod, d, s);
      1: m_ctrl = merge(m_ctrl, d, s) & ~32'h1;
      3: m_scr  = merge(m_scr, d, s);
      default: ;
    endcase
    awvalid = 1'b0; wvalid = 1'b0;
    @(negedge clk);
    check({req, " R11 bvalid"}, bvalid, 1'b1);
    hold = $urandom_range(0, 2);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R11 bvalid held", bvalid, 1'b1);
    end
    check("R11 bresp", bresp, 2'b00);
    bready = 1'b1;
    @(posedge clk);
    #1 bready = 1'b0;
    @(negedge clk);
    check("R11 bvalid drop", bvalid, 1'b0);
  endtask

  task automatic rd(int idx, string req, output logic [DW-1:0] got);
    logic [DW-1:0] exp;
    int hold;
    @(negedge clk);
    araddr = AW'(idx * 4); arvalid = 1'b1; rready = 1'b0;
    do @(negedge clk); while (!arready);
    exp = m_read(idx);
    @(posedge clk);
    #1 arvalid = 1'b0;
    @(negedge clk);
    check({req, " R11 rvalid"}, rvalid, 1'b1);
    check({req, " R12 rdata"}, rdata, exp);
    got = rdata;
    hold = $urandom_range(0, 2);
    for (int i = 0; i < hold; i++) begin
      @(negedge clk);
      check("R11 rdata held", rdata, exp);
    end
    check("R11 rresp", rresp, 2'b00);
    rready = 1'b1;
    @(posedge clk);
    #1 rready = 1'b0;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_err++;
    $display("FAIL watchdog expired actual=running expected=done");
    finish_run();
  end

  initial begin
    logic [DW-1:0] v, c0;
    void'($urandom(32'd4242));
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    check("R1 irq", irq, 1'b0);
    check("R1 bvalid", bvalid, 1'b0);
    check("R1 rvalid", rvalid, 1'b0);
    irq_mon = 1;
    for (int i = 0; i < 4; i++) begin
      rd(i, "R1 reg", v);
      if (i != 1) check("R1 zero", v, '0);
    end

    // R2 / R5 byte strobes
    wr(0, 32'hA1B2C3D4, 4'b0101, "R2");
    rd(0, "R2", v);
    check("R2 strobe lanes", v, 32'h00B200D4);
    wr(3, 32'hDEADBEEF, 4'b1111, "R5");
    wr(3, 32'h11223344, 4'b1000, "R5");
    rd(3, "R5", v);
    check("R5 scratch", v, 32'h11ADBEEF);

    // R3 control: stored bits, bit0 gives flag
    wr(0, 32'd1000, 4'hF, "R3");
    wr(1, 32'hF0000001, 4'hF, "R3");
    rd(1, "R3", v);
    check("R3 ctrl readback", v, 32'hF0000000);

    // R6 count and hold
    wr(1, 32'h2, 4'hF, "R6");
    repeat (5) @(negedge clk);
    rd(2, "R6 running", c0);
    wr(1, 32'h0, 4'hF, "R6");
    rd(2, "R6 held a", v);
    repeat (6) @(negedge clk);
    rd(2, "R6 held b", c0);
    check("R6 hold", c0, v);

    // R4 count is read-only
    wr(2, 32'h12345678, 4'hF, "R4");
    rd(2, "R4", v);
    check("R4 no effect", v, c0);
    rd(0, "R4 mod", v);
    check("R4 mod intact", v, 32'd1000);

    // R7 period
    wr(0, 32'd7, 4'hF, "R7");
    wr(1, 32'h2, 4'hF, "R7");
    repeat (30) @(negedge clk);
    check("R7 period", last_period, 7);

    // R8 modulo lowered below count
    wr(0, 32'd40, 4'hF, "R8");
    repeat (8) @(negedge clk);
    wr(0, 32'd3, 4'hF, "R8");
    rd(2, "R8 count", v);
    rd(1, "R8 flag", v);

    // R9 modulo zero
    wr(0, 32'd0, 4'hF, "R9");
    repeat (3) @(negedge clk);
    rd(1, "R9", v);
    check("R9 flag high", v[0], 1'b1);
    rd(2, "R9", v);
    check("R9 count zero", v, '0);

    // random mix
    for (int it = 0; it < 300; it++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0: wr(0, DW'($urandom_range(0, 20)), 4'hF, "rand R2");
        1: wr(1, $urandom & 32'hFFFF_FFFE | (($urandom_range(0, 3) != 0) ? 32'h2 : 32'h0), 4'hF, "rand R3");
        2: wr(int'($urandom_range(2, 3)), $urandom, 4'($urandom), "rand R4");
        default: rd(int'($urandom_range(0, 3)), "rand R12", v);
      endcase
      repeat ($urandom_range(0, 4)) @(negedge clk);
    end
    finish_run();
  end
endmodule